// File: doc/BRIEF.md
# Vector Priority Interrupt Acceptance Unit

This block sits between the interrupt sources of a processor and its interrupt entry logic. Each request arrives as an 8-bit vector. The upper four bits of the vector give its priority class, from 0 (lowest) to 15 (highest). Vectors below 32 are reserved for the processor and are never taken as requests. Each of the 16 classes has one holding slot, for a request that has arrived but is not yet taken, and one in-service slot, for a request the processor has taken and not yet retired.

The unit presents the highest-class held vector on its request line only when that class is strictly above both the task-priority class and the highest class now in service. This lets a more urgent class interrupt a less urgent handler. When the processor acknowledges, the held entry moves into service. An end-of-interrupt strobe retires the highest in-service class, and the held entries are weighed again on the next cycle. Software writes the task-priority register through a single write port. Only its upper four bits, the class, take part in masking.

Top module: `prio_accept_unit`

## Requirements
- R1: After reset no vector is held or in service, irqOut is low, and the task-priority register is zero, so a class-2 vector such as 0x25 is delivered without any register write.
- R2: A request whose vector is below 32 is ignored, and irqVector never shows such a vector.
- R3: The class of a vector is bits [7:4]. When several classes are held, irqVector shows the held vector of the highest class, all eight bits intact.
- R4: A held vector is offered only if its class is strictly greater than bits [7:4] of the task-priority register. A class value of 15 there blocks every vector.
- R5: A held vector is offered only if its class is strictly greater than the highest class in service. A higher class may therefore preempt a lower class in service, while an equal or lower class waits.
- R6: An acknowledge while irqOut is high moves the offered vector from holding to in-service and frees its holding slot. The same vector is not offered again in the next cycle.
- R7: A request for a class whose holding slot already holds a different vector is dropped. It is never delivered later.
- R8: A request whose vector equals the vector already held in its class merges with it and is delivered only once.
- R9: An end-of-interrupt strobe retires only the highest class in service. Held vectors are weighed again against the remaining state, and a newly eligible vector shows on the outputs one cycle after the strobe.
- R10: An end-of-interrupt strobe with nothing in service changes no held entry.
- R11: An acknowledge while irqOut is low has no effect. The held vector stays held and is offered once it becomes eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe for reqVector |
| reqVector | input | 8 | Vector of the incoming request |
| ackIn | input | 1 | Processor takes the offered vector |
| tprWrEn | input | 1 | Write strobe for the task-priority register |
| tprWrData | input | 8 | Task-priority value; bits [7:4] are the class |
| eoiStrobe | input | 1 | End-of-interrupt: retire the highest in-service class |
| irqOut | output | 1 | A deliverable vector is offered |
| irqVector | output | 8 | Offered vector, zero when irqOut is low |

## Verification
Requests are applied in mixed order across classes 2, 4, 5, 7, 9 and 14, so the highest-class selection can be told apart from arrival order. The task-priority class is moved above, equal to and below a held class, which separates a strict compare from a non-strict one. Nested handlers are built and then retired one strobe at a time, including an acknowledge and a strobe in the same cycle, to show that only the top in-service class is retired. A busy class is then given a repeated vector and a different one, and the later delivery sequence tells a merge apart from a drop.

// File: rtl/prio_accept_pkg.sv
package prio_accept_pkg;

  // Vector and class geometry
  parameter int VEC_W   = 8;
  parameter int CLASS_W = 4;
  localparam int NUM_CLASS = 1 << CLASS_W;
  localparam int SUB_W     = VEC_W - CLASS_W;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic               ackTake;      // move holding entry of ackClass into service
    logic [CLASS_W-1:0] ackClass;
    logic               retire;       // clear in-service entry of retireClass
    logic [CLASS_W-1:0] retireClass;
  } ctrl_strobe_t;

endpackage

// File: rtl/pa_prio_enc.sv
module pa_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Highest set bit wins: later iterations override earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import prio_accept_pkg::*;
#(
  parameter int MIN_VECTOR = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic [VEC_W-1:0]                  reqVector,
  input  logic                              tprWrEn,
  input  logic [VEC_W-1:0]                  tprWrData,
  input  ctrl_strobe_t                      stb,
  output logic [NUM_CLASS-1:0]              holdMask,
  output logic [NUM_CLASS-1:0][SUB_W-1:0]   holdSub,
  output logic [NUM_CLASS-1:0]              isrMask,
  output logic [CLASS_W-1:0]                tprClass
);

  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VECTOR);

  logic               reqOk;
  logic [CLASS_W-1:0] reqClass;
  logic [SUB_W-1:0]   reqSub;
  logic [SUB_W-1:0]   unusedTprSub;

  assign reqOk    = reqValid && (reqVector >= MIN_V);
  assign reqClass = reqVector[VEC_W-1 -: CLASS_W];
  assign reqSub   = reqVector[SUB_W-1:0];

  // Task-priority class; the low field of the written value takes no part
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tprClass <= '0;
    else if (tprWrEn) tprClass <= tprWrData[VEC_W-1 -: CLASS_W];
  end
  assign unusedTprSub = tprWrData[SUB_W-1:0];

  // One holding slot and one in-service slot per class
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    logic             ackHere;
    logic             retireHere;
    logic             reqHere;
    logic             holdV;
    logic             isrV;
    logic [SUB_W-1:0] holdS;

    assign ackHere    = stb.ackTake && (stb.ackClass == CLASS_W'(c));
    assign retireHere = stb.retire  && (stb.retireClass == CLASS_W'(c));
    assign reqHere    = reqOk && (reqClass == CLASS_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdV <= 1'b0;
        holdS <= '0;
        isrV  <= 1'b0;
      end else begin
        // acknowledge frees the slot first; a request may refill it
        if (ackHere) holdV <= 1'b0;
        // empty slot takes the request; equal vector merges; other vector drops
        if (reqHere && (!holdV || ackHere)) begin
          holdV <= 1'b1;
          holdS <= reqSub;
        end
        if (ackHere)         isrV <= 1'b1;
        else if (retireHere) isrV <= 1'b0;
      end
    end

    assign holdMask[c] = holdV;
    assign holdSub[c]  = holdS;
    assign isrMask[c]  = isrV;
  end

endmodule

// File: rtl/pa_control.sv
module pa_control
  import prio_accept_pkg::*;
(
  input  logic [NUM_CLASS-1:0]             holdMask,
  input  logic [NUM_CLASS-1:0][SUB_W-1:0]  holdSub,
  input  logic [NUM_CLASS-1:0]             isrMask,
  input  logic [CLASS_W-1:0]               tprClass,
  input  logic                             ackIn,
  input  logic                             eoiStrobe,
  output ctrl_strobe_t                     stb,
  output logic                             irqOut,
  output logic [VEC_W-1:0]                 irqVector
);

  logic               holdFound;
  logic [CLASS_W-1:0] holdTop;
  logic               isrFound;
  logic [CLASS_W-1:0] isrTop;
  logic               aboveTpr;
  logic               aboveIsr;
  logic               deliver;

  pa_prio_enc #(.N(NUM_CLASS), .IDX_W(CLASS_W)) holdEnc_i (
    .mask  (holdMask),
    .found (holdFound),
    .idx   (holdTop)
  );

  pa_prio_enc #(.N(NUM_CLASS), .IDX_W(CLASS_W)) isrEnc_i (
    .mask  (isrMask),
    .found (isrFound),
    .idx   (isrTop)
  );

  // Strict compares: an equal class never gets through
  assign aboveTpr = holdTop > tprClass;
  assign aboveIsr = !isrFound || (holdTop > isrTop);
  assign deliver  = holdFound && aboveTpr && aboveIsr;

  always_comb begin
    stb.ackTake     = ackIn && deliver;
    stb.ackClass    = holdTop;
    stb.retire      = eoiStrobe && isrFound;
    stb.retireClass = isrTop;
  end

  assign irqOut    = deliver;
  assign irqVector = deliver ? {holdTop, holdSub[holdTop]} : '0;

endmodule

// File: rtl/prio_accept_unit.sv
module prio_accept_unit
  import prio_accept_pkg::*;
#(
  parameter int MIN_VECTOR = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             ackIn,
  input  logic             tprWrEn,
  input  logic [VEC_W-1:0] tprWrData,
  input  logic             eoiStrobe,
  output logic             irqOut,
  output logic [VEC_W-1:0] irqVector
);

  ctrl_strobe_t                     stb;
  logic [NUM_CLASS-1:0]             holdMask;
  logic [NUM_CLASS-1:0][SUB_W-1:0]  holdSub;
  logic [NUM_CLASS-1:0]             isrMask;
  logic [CLASS_W-1:0]               tprClass;

  pa_datapath #(.MIN_VECTOR(MIN_VECTOR)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqVector (reqVector),
    .tprWrEn   (tprWrEn),
    .tprWrData (tprWrData),
    .stb       (stb),
    .holdMask  (holdMask),
    .holdSub   (holdSub),
    .isrMask   (isrMask),
    .tprClass  (tprClass)
  );

  pa_control control_i (
    .holdMask  (holdMask),
    .holdSub   (holdSub),
    .isrMask   (isrMask),
    .tprClass  (tprClass),
    .ackIn     (ackIn),
    .eoiStrobe (eoiStrobe),
    .stb       (stb),
    .irqOut    (irqOut),
    .irqVector (irqVector)
  );

endmodule

// File: rtl/pa_checker.sv
module pa_checker
  import prio_accept_pkg::*;
#(
  parameter int MIN_VECTOR = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [VEC_W-1:0] reqVector,
  input logic             ackIn,
  input logic             tprWrEn,
  input logic [VEC_W-1:0] tprWrData,
  input logic             eoiStrobe,
  input logic             irqOut,
  input logic [VEC_W-1:0] irqVector
);

  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VECTOR);

  // Port-side view of the task-priority class
  logic [CLASS_W-1:0] tprSeen;
  logic               unusedChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tprSeen <= '0;
    else if (tprWrEn) tprSeen <= tprWrData[VEC_W-1 -: CLASS_W];
  end
  assign unusedChk = reqValid ^ (^reqVector) ^ eoiStrobe;

  // R2
  reserved_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqVector >= MIN_V));

  // R4
  tpr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqVector[VEC_W-1 -: CLASS_W] > tprSeen));

  // R6
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> (!irqOut || (irqVector != $past(irqVector))));

  // R5
  nest_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=>
      (!irqOut || (irqVector[VEC_W-1 -: CLASS_W] > $past(irqVector[VEC_W-1 -: CLASS_W]))));

endmodule

bind prio_accept_unit pa_checker #(.MIN_VECTOR(MIN_VECTOR)) checker_i (.*);

// File: tb/prio_accept_unit_tb_top.sv
`timescale 1ns/1ps
module prio_accept_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic       ackIn = 1'b0;
  logic       tprWrEn = 1'b0;
  logic [7:0] tprWrData = '0;
  logic       eoiStrobe = 1'b0;
  logic       irqOut;
  logic [7:0] irqVector;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  prio_accept_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .ackIn(ackIn), .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .eoiStrobe(eoiStrobe), .irqOut(irqOut), .irqVector(irqVector)
  );

  // Step: {op, data, expIrq, expVec, requirement}
  // op: 0 idle, 1 request, 2 acknowledge, 3 end-of-interrupt, 4 task-priority write
  localparam int NSTEP = 40;
  localparam logic [27:0] STEPS [NSTEP] = '{
    28'h0_00_0_00_1,  // R1 idle after reset
    28'h1_10_0_00_2,  // R2 reserved vector
    28'h1_1F_0_00_2,  // R2 top reserved vector
    28'h1_25_1_25_1,  // R1 zero task priority lets class 2 through
    28'h1_73_1_73_3,  // R3 higher class takes over
    28'h1_41_1_73_3,  // R3 lower arrival does not displace
    28'h4_70_0_00_4,  // R4 equal class blocked
    28'h4_60_1_73_4,  // R4 one below passes
    28'h4_F0_0_00_4,  // R4 class 15 blocks all
    28'h4_00_1_73_4,  // R4 cleared
    28'h2_00_0_00_6,  // R6 0x73 into service
    28'h1_55_0_00_5,  // R5 lower class waits
    28'h1_9A_1_9A_5,  // R5 higher class preempts
    28'h2_00_0_00_6,  // R6 0x9A into service
    28'h3_00_0_00_9,  // R9 retire class 9, class 7 still blocks
    28'h3_00_1_55_9,  // R9 retire class 7, class 5 offered
    28'h2_00_0_00_6,  // R6 0x55 into service
    28'h1_58_0_00_7,  // R7 holding slot of busy class filled
    28'h1_5C_0_00_7,  // R7 third request dropped
    28'h1_58_0_00_8,  // R8 repeat merges
    28'h3_00_1_58_9,  // R9 held 0x58 offered
    28'h2_00_0_00_6,  // R6
    28'h3_00_1_41_7,  // R7 0x5C lost, R8 0x58 not repeated
    28'h2_00_0_00_6,  // R6
    28'h3_00_1_25_9,  // R9
    28'h2_00_0_00_6,  // R6
    28'h3_00_0_00_9,  // R9 everything retired
    28'h3_00_0_00_A,  // R10 strobe with nothing in service
    28'h4_F0_0_00_4,  // R4 block all
    28'h1_30_0_00_4,  // R4 held but blocked
    28'h2_00_0_00_B,  // R11 acknowledge while irq low
    28'h4_00_1_30_B,  // R11 vector still held
    28'h2_00_0_00_6,  // R6
    28'h3_00_0_00_9,  // R9
    28'h4_F0_0_00_A,  // R10 block all
    28'h1_66_0_00_A,  // R10 held while blocked
    28'h3_00_0_00_A,  // R10 strobe with empty in-service
    28'h4_00_1_66_A,  // R10 held entry untouched
    28'h2_00_0_00_6,  // R6
    28'h3_00_0_00_9   // R9
  };

  task automatic drive(input bit rq, input logic [7:0] v, input bit ak,
                       input bit eo, input bit tw, input logic [7:0] td);
    @(negedge clk);
    reqValid  = rq;
    reqVector = v;
    ackIn     = ak;
    eoiStrobe = eo;
    tprWrEn   = tw;
    tprWrData = td;
    @(posedge clk);
    #1;
    reqValid  = 1'b0;
    ackIn     = 1'b0;
    eoiStrobe = 1'b0;
    tprWrEn   = 1'b0;
  endtask

  task automatic check(input bit expIrq, input logic [7:0] expVec, input int req);
    testCount++;
    if (irqOut !== expIrq || (expIrq && irqVector !== expVec)) begin
      failCount++;
      $display("FAIL R%0d: irqOut=%0b irqVector=%02h expected irqOut=%0b irqVector=%02h",
               req, irqOut, irqVector, expIrq, expVec);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check(1'b0, 8'h00, 1);  // R1 reset state

    for (int i = 0; i < NSTEP; i++) begin
      logic [3:0] op;
      logic [7:0] dat;
      op  = STEPS[i][27:24];
      dat = STEPS[i][23:16];
      case (op)
        4'h1:    drive(1'b1, dat, 1'b0, 1'b0, 1'b0, 8'h00);
        4'h2:    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        4'h3:    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        4'h4:    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, dat);
        default: drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
      endcase
      check(STEPS[i][12], STEPS[i][11:4], int'(STEPS[i][3:0]));
    end

    // R1: reset in mid-operation clears held state and the task priority
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hF0);
    drive(1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 8'h00);
    check(1'b0, 8'h00, 4);  // R4 blocked by class 15
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 check(1'b0, 8'h00, 1);
    @(negedge clk) rstN = 1'b1;
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check(1'b0, 8'h00, 1);  // R1 0x88 gone
    drive(1'b1, 8'h21, 1'b0, 1'b0, 1'b0, 8'h00);
    check(1'b1, 8'h21, 1);  // R1 task priority back to zero

    // R9: acknowledge and end-of-interrupt in the same cycle
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    check(1'b0, 8'h00, 6);
    drive(1'b1, 8'hE0, 1'b0, 1'b0, 1'b0, 8'h00);
    check(1'b1, 8'hE0, 5);  // R5 class 14 preempts class 2
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00);
    check(1'b0, 8'h00, 9);
    drive(1'b1, 8'h2F, 1'b0, 1'b0, 1'b0, 8'h00);
    check(1'b0, 8'h00, 5);  // R5 class 14 in service blocks
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    check(1'b1, 8'h2F, 9);  // R9 class 2 was retired by the combined cycle

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule